// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This unit compares two IEEE-754 operands, both single or both double precision, and turns the result into a 32-bit condition-code word. The word has one bit for each relation a branch or a trap test might need. Among them are unordered-aware relations that are true when either operand is a NaN. There are also four range-check bits that treat the second operand as a nonnegative upper limit and test the first operand against it.

A compare request is one strobe carrying several items:
- the two operands;
- a precision select;
- a flag that selects the quiet ("unordered") compare opcode;
- a legacy flag that strips the unordered-aware relations;
- a destination register index.

One cycle after the strobe, the unit presents the condition word, a write enable and an invalid-operation pulse. The write enable is withheld for destination register 0. Single-precision operands use the low 32 bits of each operand bus, and the upper bits are ignored.

Top module: `fcmp_cc_unit`

## Requirements
- R1: The condition word has these bits: bit0 unordered (UN), bit1 ordered (LEG), bit2 equal (EQ), bit3 not equal (NE), bit4 greater (GT), bit5 less-or-equal (LE), bit6 less (LT), bit7 greater-or-equal (GE), bit8 out of range (OU), bit9 inside bounds (IB), bit10 inside range (IN), bit11 on-or-inside bounds (OB), bit12 unordered-or-equal (UE), bit13 less-or-greater (LG), bit14 unordered-or-greater (UG), bit15 unordered-or-less-or-equal (ULE), bit16 unordered-or-less (UL), bit17 unordered-or-greater-or-equal (UGE). Bits 31:18 are always zero.
- R2: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. The single format has an 8-bit exponent and a 23-bit fraction in bits 30:0 of the bus. The double format has an 11-bit exponent and a 52-bit fraction. If either operand is a NaN, the only base relation is UN.
- R3: The NaN test for the invalid pulse looks at operand A first. If A is a NaN, invalid is raised when the opcode is the ordinary compare (unord_op=0) or when A is signaling, meaning the top fraction bit is clear. Only when A is not a NaN does the same rule apply to operand B.
- R4: For ordered operands, exactly one base result holds: EQ; LT with NE; or GT with NE. The comparison follows IEEE value order, so +0 and -0 compare equal and infinities sit at the ends.
- R5: Derived bits are added as follows:
  - UN adds NE, UE, UG, ULE, UL and UGE.
  - EQ adds LE, GE, UE, LEG, ULE and UGE.
  - LT adds LE, LG, LEG, ULE and UL.
  - GT adds GE, LG, LEG, UG and UGE.
- R6: With legacy=1, bits 17:12 (UE, LG, UG, ULE, UL, UGE) read zero. All other bits are unchanged.
- R7: Bits 11:8 are all zero when the result is unordered or when the sign bit of B is set, which includes B = -0.
- R8: When the result is ordered and B's sign bit is clear, the range bits are chosen by the first of these rules that applies:
  - A equals B, or A is ±0: IB and OB.
  - A is greater than B: OU and OB.
  - A's sign bit is clear: IB and IN.
  - Otherwise: OU and OB.
- R9: wr_en is high with out_valid exactly when the registered destination index is nonzero, and wr_idx carries that index.
- R10: out_valid, wr_en and invalid_pulse are high for exactly the cycle after an in_valid cycle, and low after a cycle without in_valid.
- R11: While rst is high, on the next edge out_valid, wr_en and invalid_pulse go low and cc_word and wr_idx clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| op_a | input | 64 | First operand (single: bits 31:0) |
| op_b | input | 64 | Second operand / upper limit (single: bits 31:0) |
| prec_dbl | input | 1 | 1 = double precision, 0 = single |
| unord_op | input | 1 | 1 = quiet compare opcode |
| legacy | input | 1 | 1 = clear bits 17:12 |
| dest_idx | input | 5 | Destination register index |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| cc_word | output | 32 | Condition-code word |
| wr_en | output | 1 | Register write enable, low for index 0 |
| wr_idx | output | 5 | Registered destination index |
| invalid_pulse | output | 1 | Invalid-operation exception pulse |

## Verification
The bench sweeps every pair from a set of special values in both precisions. The set is ±0, ±1, 2, the smallest denormals of both signs, ±infinity, the largest finite value, a value one unit above 1, one quiet NaN and two signaling NaNs. The zero pairs separate IEEE equality from bitwise equality. The denormal and one-unit pairs catch magnitude-comparator slips. Mixed signs and infinities test sign handling in both value order and the range rules. NaN pairs in both operand positions, run under both opcodes, show the operand-A priority in the invalid decision. Every pair is run with and without legacy mode, across destination indices that include 0 and 31. In single precision the upper 32 bits of each bus hold junk that looks like a double NaN, which proves that those bits are ignored.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // condition-word bit positions (software decodes these)
  localparam int CC_UN  = 0;
  localparam int CC_LEG = 1;
  localparam int CC_EQ  = 2;
  localparam int CC_NE  = 3;
  localparam int CC_GT  = 4;
  localparam int CC_LE  = 5;
  localparam int CC_LT  = 6;
  localparam int CC_GE  = 7;
  localparam int CC_OU  = 8;
  localparam int CC_IB  = 9;
  localparam int CC_IN  = 10;
  localparam int CC_OB  = 11;
  localparam int CC_UE  = 12;
  localparam int CC_LG  = 13;
  localparam int CC_UG  = 14;
  localparam int CC_ULE = 15;
  localparam int CC_UL  = 16;
  localparam int CC_UGE = 17;
  localparam int CC_USED = 18;

  typedef enum logic {
    PREC_SNG = 1'b0,
    PREC_DBL = 1'b1
  } prec_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
    logic sign;
  } opcls_t;

endpackage

// File: rtl/fcmp_field_dec.sv
module fcmp_field_dec
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int FW    = 1 + EXP_W + FRAC_W
) (
  input  logic [FW-1:0] word,
  output opcls_t        cls,
  output logic [FW-2:0] mag
);

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones;
  logic              frac_nz;

  assign expo     = word[FW-2 -: EXP_W];
  assign frac     = word[FRAC_W-1:0];
  assign exp_ones = &expo;
  assign frac_nz  = |frac;

  assign cls.nan  = exp_ones & frac_nz;
  assign cls.snan = exp_ones & frac_nz & ~frac[FRAC_W-1];
  assign cls.zero = ~|word[FW-2:0];
  assign cls.sign = word[FW-1];
  assign mag      = word[FW-2:0];

endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_S  = 8,
  parameter int FRAC_S = 23,
  parameter int EXP_D  = 11,
  parameter int FRAC_D = 52,
  localparam int SW    = 1 + EXP_S + FRAC_S,
  localparam int DW    = 1 + EXP_D + FRAC_D
) (
  input  logic [DW-1:0] opnd,
  input  prec_e         prec,
  output opcls_t        cls,
  output logic [DW-2:0] mag
);

  opcls_t          cls_s;
  opcls_t          cls_d;
  logic [SW-2:0]   mag_s;
  logic [DW-2:0]   mag_d;

  fcmp_field_dec #(.EXP_W(EXP_S), .FRAC_W(FRAC_S)) u_dec_s (
    .word (opnd[SW-1:0]),
    .cls  (cls_s),
    .mag  (mag_s)
  );

  fcmp_field_dec #(.EXP_W(EXP_D), .FRAC_W(FRAC_D)) u_dec_d (
    .word (opnd),
    .cls  (cls_d),
    .mag  (mag_d)
  );

  always_comb begin
    if (prec == PREC_DBL) begin
      cls = cls_d;
      mag = mag_d;
    end else begin
      cls = cls_s;
      mag = {{(DW-SW){1'b0}}, mag_s};
    end
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  opcls_t           cls_a,
  input  opcls_t           cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             rel_eq,
  output logic             rel_lt,
  output logic             rel_gt
);

  logic mag_eq;
  logic mag_lt;

  assign mag_eq = (mag_a == mag_b);
  assign mag_lt = (mag_a < mag_b);

  always_comb begin
    rel_eq = 1'b0;
    rel_lt = 1'b0;
    if (cls_a.zero && cls_b.zero) begin
      rel_eq = 1'b1;
    end else if (cls_a.sign != cls_b.sign) begin
      rel_lt = cls_a.sign;
    end else if (mag_eq) begin
      rel_eq = 1'b1;
    end else begin
      rel_lt = cls_a.sign ? ~mag_lt : mag_lt;
    end
    rel_gt = ~rel_eq & ~rel_lt;
  end

endmodule

// File: rtl/fcmp_ccode.sv
module fcmp_ccode
  import fcmp_pkg::*;
#(
  parameter int CC_W = 32
) (
  input  logic            unord,
  input  logic            rel_eq,
  input  logic            rel_lt,
  input  logic            legacy,
  input  logic            sign_a,
  input  logic            zero_a,
  input  logic            sign_b,
  output logic [CC_W-1:0] cc
);

  always_comb begin
    cc = '0;
    // base relation
    if (unord) begin
      cc[CC_UN] = 1'b1;
    end else if (rel_eq) begin
      cc[CC_EQ] = 1'b1;
    end else if (rel_lt) begin
      cc[CC_LT] = 1'b1;
      cc[CC_NE] = 1'b1;
    end else begin
      cc[CC_GT] = 1'b1;
      cc[CC_NE] = 1'b1;
    end
    // derivation chain, each step sees the ones before it
    if (cc[CC_UN]) begin
      cc[CC_NE]  = 1'b1;
      cc[CC_UE]  = 1'b1;
      cc[CC_UG]  = 1'b1;
      cc[CC_ULE] = 1'b1;
      cc[CC_UL]  = 1'b1;
      cc[CC_UGE] = 1'b1;
    end
    if (cc[CC_EQ]) begin
      cc[CC_LE] = 1'b1;
      cc[CC_GE] = 1'b1;
      cc[CC_UE] = 1'b1;
    end
    if (cc[CC_GT]) cc[CC_GE] = 1'b1;
    if (cc[CC_LT]) cc[CC_LE] = 1'b1;
    if (cc[CC_LT] | cc[CC_GT]) cc[CC_LG] = 1'b1;
    if (cc[CC_LT] | cc[CC_GT] | cc[CC_EQ]) cc[CC_LEG] = 1'b1;
    if (cc[CC_GT]) cc[CC_UG]  = 1'b1;
    if (cc[CC_LE]) cc[CC_ULE] = 1'b1;
    if (cc[CC_LT]) cc[CC_UL]  = 1'b1;
    if (cc[CC_GE]) cc[CC_UGE] = 1'b1;
    // legacy mask
    if (legacy) begin
      cc[CC_UE]  = 1'b0;
      cc[CC_LG]  = 1'b0;
      cc[CC_UG]  = 1'b0;
      cc[CC_ULE] = 1'b0;
      cc[CC_UL]  = 1'b0;
      cc[CC_UGE] = 1'b0;
    end
    // range bits against a nonnegative limit
    if (!cc[CC_UN] && !sign_b) begin
      if (cc[CC_EQ] || zero_a) begin
        cc[CC_IB] = 1'b1;
        cc[CC_OB] = 1'b1;
      end else if (cc[CC_GT]) begin
        cc[CC_OU] = 1'b1;
        cc[CC_OB] = 1'b1;
      end else if (!sign_a) begin
        cc[CC_IB] = 1'b1;
        cc[CC_IN] = 1'b1;
      end else begin
        cc[CC_OU] = 1'b1;
        cc[CC_OB] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_S  = 8,
  parameter int FRAC_S = 23,
  parameter int EXP_D  = 11,
  parameter int FRAC_D = 52,
  parameter int IDX_W  = 5,
  parameter int CC_W   = 32,
  localparam int OP_W  = 1 + EXP_D + FRAC_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             prec_dbl,
  input  logic             unord_op,
  input  logic             legacy,
  input  logic [IDX_W-1:0] dest_idx,
  output logic             out_valid,
  output logic [CC_W-1:0]  cc_word,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             invalid_pulse
);

  localparam int MAG_W = OP_W - 1;

  prec_e            prec;
  opcls_t           cls [2];
  logic [MAG_W-1:0] mag [2];
  logic [OP_W-1:0]  opnd [2];
  logic             rel_eq, rel_lt, rel_gt;
  logic             unord;
  logic             inv_next;
  logic [CC_W-1:0]  cc_next;

  assign prec    = prec_e'(prec_dbl);
  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(
      .EXP_S(EXP_S), .FRAC_S(FRAC_S), .EXP_D(EXP_D), .FRAC_D(FRAC_D)
    ) u_cls (
      .opnd (opnd[g]),
      .prec (prec),
      .cls  (cls[g]),
      .mag  (mag[g])
    );
  end

  fcmp_order #(.MAG_W(MAG_W)) u_ord (
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .mag_a  (mag[0]),
    .mag_b  (mag[1]),
    .rel_eq (rel_eq),
    .rel_lt (rel_lt),
    .rel_gt (rel_gt)
  );

  assign unord = cls[0].nan | cls[1].nan;

  // operand A is examined first; B only when A is ordered
  always_comb begin
    if (cls[0].nan)
      inv_next = ~unord_op | cls[0].snan;
    else if (cls[1].nan)
      inv_next = ~unord_op | cls[1].snan;
    else
      inv_next = 1'b0;
  end

  fcmp_ccode #(.CC_W(CC_W)) u_cc (
    .unord  (unord),
    .rel_eq (rel_eq),
    .rel_lt (rel_lt & ~rel_gt),
    .legacy (legacy),
    .sign_a (cls[0].sign),
    .zero_a (cls[0].zero),
    .sign_b (cls[1].sign),
    .cc     (cc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      wr_en         <= 1'b0;
      invalid_pulse <= 1'b0;
      cc_word       <= '0;
      wr_idx        <= '0;
    end else begin
      out_valid     <= in_valid;
      wr_en         <= in_valid & (|dest_idx);
      invalid_pulse <= in_valid & inv_next;
      if (in_valid) begin
        cc_word <= cc_next;
        wr_idx  <= dest_idx;
      end
    end
  end

endmodule

// File: rtl/fcmp_cc_checker.sv
module fcmp_cc_checker
  import fcmp_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CC_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             legacy,
  input logic             out_valid,
  input logic [CC_W-1:0]  cc_word,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             invalid_pulse
);

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((cc_word >> CC_USED) == '0));

  a_r3_invalid_only_unordered: assert property (@(posedge clk) disable iff (rst)
    invalid_pulse |-> cc_word[CC_UN]);

  a_r4_single_base: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({cc_word[CC_UN], cc_word[CC_EQ], cc_word[CC_LT], cc_word[CC_GT]}) == 1);

  a_r5_ne_vs_eq: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (cc_word[CC_NE] != cc_word[CC_EQ]));

  a_r6_legacy_mask: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy) |=> (cc_word[CC_UGE:CC_UE] == '0));

  a_r7_no_range_unordered: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cc_word[CC_UN]) |-> (cc_word[CC_OB:CC_OU] == '0));

  a_r8_ib_ou_exclusive: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({cc_word[CC_IB], cc_word[CC_OU]}));

  a_r9_wen_needs_index: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (out_valid && wr_idx != '0));

  a_r9_wen_when_index: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_idx != '0) |-> wr_en);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !invalid_pulse && !wr_en));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && !invalid_pulse && cc_word == '0));

endmodule

bind fcmp_cc_unit fcmp_cc_checker #(.IDX_W(IDX_W), .CC_W(CC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .legacy        (legacy),
  .out_valid     (out_valid),
  .cc_word       (cc_word),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .invalid_pulse (invalid_pulse)
);

// File: tb/sim_fcmp_cc_unit.sv
module sim_fcmp_cc_unit;

  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        prec_dbl = 1'b0;
  logic        unord_op = 1'b0;
  logic        legacy = 1'b0;
  logic [4:0]  dest_idx = '0;
  logic        out_valid;
  logic [31:0] cc_word;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic        invalid_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fcmp_cc_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .prec_dbl(prec_dbl), .unord_op(unord_op), .legacy(legacy),
    .dest_idx(dest_idx), .out_valid(out_valid), .cc_word(cc_word),
    .wr_en(wr_en), .wr_idx(wr_idx), .invalid_pulse(invalid_pulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // single-precision samples: bit pattern and value
  function automatic logic [31:0] s_bits(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h8000_0000;
      2: return 32'h3F80_0000;   3: return 32'hBF80_0000;
      4: return 32'h4000_0000;   5: return 32'h0000_0001;
      6: return 32'h8000_0001;   7: return 32'h7F80_0000;
      8: return 32'hFF80_0000;   9: return 32'h7FC0_0000;
      10: return 32'h7F80_0001;  11: return 32'hFFA0_0000;
      12: return 32'h7F7F_FFFF;  default: return 32'h3F80_0001;
    endcase
  endfunction

  function automatic real s_val(input int i);
    case (i)
      0: return 0.0;    1: return -0.0;
      2: return 1.0;    3: return -1.0;
      4: return 2.0;    5: return 2.0 ** (-149);
      6: return -(2.0 ** (-149));
      7: return 1.0e300; 8: return -1.0e300;
      12: return 3.4028234663852886e38;
      13: return 1.0 + 2.0 ** (-23);
      default: return 0.0;
    endcase
  endfunction

  function automatic logic [63:0] d_bits(input int i);
    case (i)
      0: return 64'h0000_0000_0000_0000;  1: return 64'h8000_0000_0000_0000;
      2: return 64'h3FF0_0000_0000_0000;  3: return 64'hBFF0_0000_0000_0000;
      4: return 64'h4000_0000_0000_0000;  5: return 64'h0000_0000_0000_0001;
      6: return 64'h8000_0000_0000_0001;  7: return 64'h7FF0_0000_0000_0000;
      8: return 64'hFFF0_0000_0000_0000;  9: return 64'h7FF8_0000_0000_0000;
      10: return 64'h7FF0_0000_0000_0001; 11: return 64'hFFF4_0000_0000_0000;
      12: return 64'h7FEF_FFFF_FFFF_FFFF; default: return 64'h3FF0_0000_0000_0001;
    endcase
  endfunction

  function automatic bit is_nan(input int i);  return (i >= 9 && i <= 11); endfunction
  function automatic bit is_snan(input int i); return (i == 10 || i == 11); endfunction

  // expected word from the requirement text (R1, R2, R4-R8)
  function automatic logic [31:0] exp_cc(input real a, input real b, input bit un,
                                         input bit sa, input bit sb, input bit lg);
    logic [31:0] c = '0;
    bit eq, lt, gt;
    eq = !un && (a == b);
    lt = !un && (a < b);
    gt = !un && !eq && !lt;
    if (un) begin
      c[0] = 1; c[3] = 1; c[12] = 1; c[14] = 1; c[15] = 1; c[16] = 1; c[17] = 1;
    end
    if (eq) begin
      c[2] = 1; c[5] = 1; c[7] = 1; c[12] = 1; c[1] = 1; c[15] = 1; c[17] = 1;
    end
    if (lt) begin
      c[6] = 1; c[3] = 1; c[5] = 1; c[13] = 1; c[1] = 1; c[15] = 1; c[16] = 1;
    end
    if (gt) begin
      c[4] = 1; c[3] = 1; c[7] = 1; c[13] = 1; c[1] = 1; c[14] = 1; c[17] = 1;
    end
    if (lg) c[17:12] = '0;
    if (!un && !sb) begin
      if (eq || a == 0.0) begin c[9] = 1; c[11] = 1; end
      else if (gt)        begin c[8] = 1; c[11] = 1; end
      else if (!sa)       begin c[9] = 1; c[10] = 1; end
      else                begin c[8] = 1; c[11] = 1; end
    end
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", {63'b0, out_valid}, 64'd0);
    chk("R11 wr_en", {63'b0, wr_en}, 64'd0);
    chk("R11 invalid", {63'b0, invalid_pulse}, 64'd0);
    chk("R11 cc_word", {32'b0, cc_word}, 64'd0);
    chk("R11 wr_idx", {59'b0, wr_idx}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      for (int ia = 0; ia < NV; ia++) begin
        for (int ib = 0; ib < NV; ib++) begin
          for (int m = 0; m < 4; m++) begin
            logic [31:0] e;
            logic [4:0] idx;
            bit un, sa, sb, inv;
            real va, vb;
            un = is_nan(ia) || is_nan(ib);
            if (p == 0) begin
              op_a = {32'h7FF8_A5C3, s_bits(ia)};
              op_b = {32'hFFF4_0F96, s_bits(ib)};
              va = s_val(ia); vb = s_val(ib);
              sa = s_bits(ia)[31]; sb = s_bits(ib)[31];
            end else begin
              op_a = d_bits(ia); op_b = d_bits(ib);
              va = un ? 0.0 : $bitstoreal(d_bits(ia));
              vb = un ? 0.0 : $bitstoreal(d_bits(ib));
              sa = d_bits(ia)[63]; sb = d_bits(ib)[63];
            end
            prec_dbl = p[0];
            unord_op = m[0];
            legacy   = m[1];
            idx = (n % 3 == 0) ? 5'd0 : (n % 3 == 1) ? 5'd31 : 5'(n % 32);
            dest_idx = idx;
            in_valid = 1'b1;
            if (is_nan(ia))      inv = !m[0] || is_snan(ia);
            else if (is_nan(ib)) inv = !m[0] || is_snan(ib);
            else                 inv = 1'b0;
            e = exp_cc(va, vb, un, sa, sb, m[1]);
            @(negedge clk);
            in_valid = 1'b0;
            chk("R10 out_valid", {63'b0, out_valid}, 64'd1);
            if (un) chk("R2 R5 unordered base", {56'b0, cc_word[7:0]}, {56'b0, e[7:0]});
            else    chk("R4 R5 ordered base", {56'b0, cc_word[7:0]}, {56'b0, e[7:0]});
            if (un || sb) chk("R7 range gated", {60'b0, cc_word[11:8]}, {60'b0, e[11:8]});
            else          chk("R8 range bits", {60'b0, cc_word[11:8]}, {60'b0, e[11:8]});
            if (m[1]) chk("R6 legacy cleared", {58'b0, cc_word[17:12]}, {58'b0, e[17:12]});
            else      chk("R5 unordered-aware", {58'b0, cc_word[17:12]}, {58'b0, e[17:12]});
            chk("R1 high bits", {50'b0, cc_word[31:18]}, 64'd0);
            chk("R3 invalid", {63'b0, invalid_pulse}, {63'b0, inv});
            chk("R9 wr_en", {63'b0, wr_en}, {63'b0, (idx != 5'd0)});
            chk("R9 wr_idx", {59'b0, wr_idx}, {59'b0, idx});
            n++;
          end
          // idle cycle: pulses must drop
          @(negedge clk);
          chk("R10 idle valid", {61'b0, out_valid, wr_en, invalid_pulse}, 64'd0);
        end
      end
    end
    // reset with a result pending
    in_valid = 1'b1;
    op_a = 64'h7FF0_0000_0000_0001;
    op_b = '0;
    dest_idx = 5'd7;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 reset beats request", {61'b0, out_valid, wr_en, invalid_pulse}, 64'd0);
    chk("R11 reset word", {32'b0, cc_word}, 64'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule